// File: doc/BRIEF.md
# Floppy Multi-Sector Write Sequencer

This block runs one write-data command against a single floppy track. A command loads the target cylinder, head, sector and size code together with the last sector number on the track and a multi-track flag. If the drive head is not yet loaded, the block raises head load and waits a programmed settle time. It then watches a stream of already decoded sector ID fields, each carrying a CRC-valid flag. When an ID matches the target address, the block pulls bytes from a host FIFO, emits the data field one byte per clock, and appends a 16-bit CRC.

After each sector it steps the sector number and searches for the next one. It stops after the last sector of the track, on terminal count, on a FIFO underrun, on a bad ID CRC, or when no matching ID turns up within two index pulses. On completion it gives a one-cycle done pulse. With that pulse it presents two status bytes and the cylinder, head, sector and size values that the result phase of the command returns.

Flux encoding, address-mark detection, drive mechanics and the FIFO itself lie outside the block.

Top module: `floppy_wr_seq`

## Requirements
- R1: When `start` arrives with `headLoaded` low, `headLoad` rises and ID fields are ignored for max(1, `settleCycles`) cycles. With `headLoaded` high, ID search begins on the next cycle. `headLoad` stays high from the cycle after `start` until the command ends.
- R2: A data field is written only after an ID whose cylinder, head, sector and size all equal the current target. Its data bytes are the FIFO bytes in read order, and each read is marked by `fifoRd` in the cycle the byte appears on `wrByte`.
- R3: Each data field is followed by two more bytes, high byte first. These hold a CRC over the field's data bytes only, using polynomial 0x1021, a preset of 0xFFFF and MSB-first processing.
- R4: After a complete sector whose number is not the end-of-track value, the target sector number rises by one and the search resumes in the same command.
- R5: If `termCount` is high in a data-byte cycle, every later byte of that field is 0x00 and no further FIFO reads occur. The CRC still follows, and the command then ends with interrupt code 00.
- R6: A data-byte cycle with `fifoEmpty` high emits 0x00 without a read, and all later bytes of the field are zero. The command then ends with interrupt code 01 and bit 4 of `st1` set.
- R7: An ID field received during the search with `idCrcOk` low ends the command with interrupt code 01 and bit 5 of `st1` set. The reported C, H and R are the unchanged target values.
- R8: A second `indexPulse` during one sector search with no matching ID ends the command with interrupt code 01 and bit 0 of `st1` set.
- R9: On a normal or underrun end, if the last sector handled was below end-of-track, the reported R is that sector plus one and C, H and N are unchanged.
- R10: If the last sector equals end-of-track, the reported R is 1 and N is unchanged. With multi-track off, C is incremented. With multi-track on and head bit 0 clear, C is unchanged and the head LSB is inverted. With multi-track on and head bit 0 set, C is incremented and the head LSB is inverted.
- R11: A data field is 128 shifted left by the size code bytes long, with the shift capped at parameter MAXN.
- R12: `done` is high for exactly one cycle per command. `st0` holds the interrupt code in bits 7:6 (00 normal, 01 abnormal) and the head LSB in bit 2. Result values hold until the next end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low asynchronous reset |
| start | input | 1 | one-cycle command start |
| cylIn | input | 8 | target cylinder |
| headIn | input | 8 | target head |
| secIn | input | 8 | first sector number |
| sizeIn | input | 8 | size code N |
| eotIn | input | 8 | last sector number of the track |
| multiTrack | input | 1 | multi-track flag |
| headLoaded | input | 1 | head already loaded at start |
| settleCycles | input | SETW | head settle wait in cycles |
| idValid | input | 1 | decoded ID field strobe |
| idCyl | input | 8 | ID cylinder |
| idHead | input | 8 | ID head |
| idSec | input | 8 | ID sector |
| idSize | input | 8 | ID size code |
| idCrcOk | input | 1 | ID CRC good |
| indexPulse | input | 1 | index hole strobe |
| termCount | input | 1 | terminal count |
| fifoEmpty | input | 1 | host FIFO has no byte |
| fifoData | input | 8 | host FIFO head byte |
| fifoRd | output | 1 | pop host FIFO |
| headLoad | output | 1 | head load request |
| wrValid | output | 1 | `wrByte` carries a field byte |
| wrByte | output | 8 | byte to the write encoder |
| done | output | 1 | command end pulse |
| st0 | output | 8 | status byte 0 |
| st1 | output | 8 | status byte 1 |
| resC | output | 8 | result cylinder |
| resH | output | 8 | result head |
| resR | output | 8 | result sector |
| resN | output | 8 | result size code |

## Verification
A sequencer stuck in the wrong state or holding a stale target address shows at the ports within one sector time. Data bytes would be missing, or the second CRC byte would be wrong or absent at the point a correct field ends, and each field is checked byte for byte, CRC included. A wrong sector counter or a mis-latched end reason shows in the one cycle where `done` is high, through the result C/H/R values and the status bytes. Pad latching errors show on the byte after terminal count or underrun, because that byte must be zero.

// File: rtl/floppy_wr_pkg.sv
package floppy_wr_pkg;

  typedef enum logic [1:0] {EMIT_NONE, EMIT_DATA, EMIT_CRCH, EMIT_CRCL} emitSel_e;
  typedef enum logic [1:0] {END_OK, END_OR, END_DE, END_MA} endCode_e;

  typedef struct packed {
    logic     loadCmd;
    logic     bumpSec;
    logic     fieldClr;
    logic     dataStep;
    logic     padByte;
    emitSel_e emit;
    logic     latchRes;
    endCode_e endCode;
  } ctlStrobe_t;

  function automatic logic [15:0] crcByte(input logic [15:0] crcIn, input logic [7:0] b);
    logic [15:0] c;
    c = crcIn;
    for (int i = 7; i >= 0; i--) begin
      if (c[15] ^ b[i]) c = {c[14:0], 1'b0} ^ 16'h1021;
      else              c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/floppy_wr_dp.sv
module floppy_wr_dp
  import floppy_wr_pkg::*;
#(
  parameter int MAXN = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strb,
  input  logic [7:0] cylIn,
  input  logic [7:0] headIn,
  input  logic [7:0] secIn,
  input  logic [7:0] sizeIn,
  input  logic [7:0] eotIn,
  input  logic       multiTrack,
  input  logic [7:0] idCyl,
  input  logic [7:0] idHead,
  input  logic [7:0] idSec,
  input  logic [7:0] idSize,
  input  logic [7:0] fifoData,
  output logic       idMatch,
  output logic       atEot,
  output logic       lastByte,
  output logic       wrValid,
  output logic [7:0] wrByte,
  output logic [7:0] st0,
  output logic [7:0] st1,
  output logic [7:0] resC,
  output logic [7:0] resH,
  output logic [7:0] resR,
  output logic [7:0] resN
);

  localparam int LENW = 8 + MAXN;
  localparam logic [7:0] MAXN8 = 8'(MAXN);

  logic [7:0] curC, curH, curR, curN, eotR;
  logic       mtR;
  logic [LENW-1:0] byteCnt, lastIdx;
  logic [15:0] crc;
  logic [7:0]  dataByte, nEff;
  logic [1:0]  icCode;

  assign nEff     = (curN > MAXN8) ? MAXN8 : curN;
  assign lastIdx  = (LENW'(128) << nEff) - LENW'(1);
  assign lastByte = (byteCnt == lastIdx);
  assign idMatch  = (idCyl == curC) && (idHead == curH) && (idSec == curR) && (idSize == curN);
  assign atEot    = (curR == eotR);
  assign dataByte = strb.padByte ? 8'h00 : fifoData;
  assign icCode   = (strb.endCode == END_OK) ? 2'b00 : 2'b01;

  always_comb begin
    wrValid = 1'b1;
    unique case (strb.emit)
      EMIT_DATA: wrByte = dataByte;
      EMIT_CRCH: wrByte = crc[15:8];
      EMIT_CRCL: wrByte = crc[7:0];
      default: begin wrByte = 8'h00; wrValid = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curC <= '0; curH <= '0; curR <= '0; curN <= '0; eotR <= '0; mtR <= 1'b0;
      byteCnt <= '0; crc <= 16'hFFFF;
      st0 <= '0; st1 <= '0; resC <= '0; resH <= '0; resR <= '0; resN <= '0;
    end else begin
      if (strb.loadCmd) begin
        curC <= cylIn; curH <= headIn; curR <= secIn; curN <= sizeIn;
        eotR <= eotIn; mtR <= multiTrack;
      end
      if (strb.bumpSec) curR <= curR + 8'd1;
      if (strb.fieldClr) begin
        byteCnt <= '0;
        crc     <= 16'hFFFF;
      end else if (strb.dataStep) begin
        byteCnt <= byteCnt + LENW'(1);
        crc     <= crcByte(crc, dataByte);
      end
      if (strb.latchRes) begin
        resN <= curN;
        resC <= curC; resH <= curH; resR <= curR;
        if (strb.endCode == END_OK || strb.endCode == END_OR) begin
          if (!atEot) begin
            resR <= curR + 8'd1;
          end else begin
            resR <= 8'd1;
            if (!mtR) resC <= curC + 8'd1;
            else begin
              resH <= curH ^ 8'd1;
              if (curH[0]) resC <= curC + 8'd1;
            end
          end
        end
        st0 <= {icCode, 3'b000, curH[0], 2'b00};
        st1 <= {2'b00, strb.endCode == END_DE, strb.endCode == END_OR, 3'b000,
                strb.endCode == END_MA};
      end
    end
  end

  p_sec_bump_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.bumpSec |=> curR == $past(curR) + 8'd1);

  p_abort_de_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latchRes && strb.endCode == END_DE) |=> (st0[7:6] == 2'b01 && st1[5]));

endmodule

// File: rtl/floppy_wr_ctl.sv
module floppy_wr_ctl
  import floppy_wr_pkg::*;
#(
  parameter int SETW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            headLoaded,
  input  logic [SETW-1:0] settleCycles,
  input  logic            idValid,
  input  logic            idCrcOk,
  input  logic            indexPulse,
  input  logic            termCount,
  input  logic            fifoEmpty,
  input  logic            idMatch,
  input  logic            atEot,
  input  logic            lastByte,
  output ctlStrobe_t      strb,
  output logic            fifoRd,
  output logic            headLoad,
  output logic            done
);

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_SCAN, S_DATA, S_CRCH, S_CRCL, S_DONE} state_e;

  state_e state, nextState;
  logic [SETW-1:0] settleCnt;
  logic idxSeen, cut, under;
  logic settleEnd;

  assign settleEnd = ({1'b0, settleCnt} + (SETW+1)'(1)) >= {1'b0, settleCycles};
  assign headLoad  = (state != S_IDLE);
  assign done      = (state == S_DONE);

  always_comb begin
    strb      = '0;
    fifoRd    = 1'b0;
    nextState = state;
    unique case (state)
      S_IDLE: if (start) begin
        strb.loadCmd = 1'b1;
        nextState    = headLoaded ? S_SCAN : S_SETTLE;
      end
      S_SETTLE: if (settleEnd) nextState = S_SCAN;
      S_SCAN: begin
        if (idValid) begin
          if (!idCrcOk) begin
            strb.latchRes = 1'b1; strb.endCode = END_DE; nextState = S_DONE;
          end else if (idMatch) begin
            strb.fieldClr = 1'b1; nextState = S_DATA;
          end
        end else if (indexPulse && idxSeen) begin
          strb.latchRes = 1'b1; strb.endCode = END_MA; nextState = S_DONE;
        end
      end
      S_DATA: begin
        strb.emit     = EMIT_DATA;
        strb.dataStep = 1'b1;
        strb.padByte  = cut | fifoEmpty;
        fifoRd        = !(cut | fifoEmpty);
        if (lastByte) nextState = S_CRCH;
      end
      S_CRCH: begin strb.emit = EMIT_CRCH; nextState = S_CRCL; end
      S_CRCL: begin
        strb.emit = EMIT_CRCL;
        if (cut || atEot) begin
          strb.latchRes = 1'b1;
          strb.endCode  = under ? END_OR : END_OK;
          nextState     = S_DONE;
        end else begin
          strb.bumpSec = 1'b1;
          nextState    = S_SCAN;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; settleCnt <= '0; idxSeen <= 1'b0; cut <= 1'b0; under <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_SETTLE) settleCnt <= settleCnt + SETW'(1);
      else                   settleCnt <= '0;
      if (state != S_SCAN)   idxSeen <= 1'b0;
      else if (indexPulse)   idxSeen <= 1'b1;
      if (state == S_IDLE && start) begin
        cut <= 1'b0; under <= 1'b0;
      end else if (state == S_DATA && !cut) begin
        if (termCount)      cut <= 1'b1;
        else if (fifoEmpty) begin cut <= 1'b1; under <= 1'b1; end
      end
    end
  end

  p_done_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_crc_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CRCH) |=> (state == S_CRCL));

  p_settle_no_data_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SETTLE) |=> (state != S_DATA));

endmodule

// File: rtl/floppy_wr_seq.sv
module floppy_wr_seq
  import floppy_wr_pkg::*;
#(
  parameter int MAXN = 2,
  parameter int SETW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [7:0]      cylIn,
  input  logic [7:0]      headIn,
  input  logic [7:0]      secIn,
  input  logic [7:0]      sizeIn,
  input  logic [7:0]      eotIn,
  input  logic            multiTrack,
  input  logic            headLoaded,
  input  logic [SETW-1:0] settleCycles,
  input  logic            idValid,
  input  logic [7:0]      idCyl,
  input  logic [7:0]      idHead,
  input  logic [7:0]      idSec,
  input  logic [7:0]      idSize,
  input  logic            idCrcOk,
  input  logic            indexPulse,
  input  logic            termCount,
  input  logic            fifoEmpty,
  input  logic [7:0]      fifoData,
  output logic            fifoRd,
  output logic            headLoad,
  output logic            wrValid,
  output logic [7:0]      wrByte,
  output logic            done,
  output logic [7:0]      st0,
  output logic [7:0]      st1,
  output logic [7:0]      resC,
  output logic [7:0]      resH,
  output logic [7:0]      resR,
  output logic [7:0]      resN
);

  ctlStrobe_t strb;
  logic idMatch, atEot, lastByte;

  floppy_wr_ctl #(.SETW(SETW)) u_ctl (
    .clk, .rstN, .start, .headLoaded, .settleCycles, .idValid, .idCrcOk,
    .indexPulse, .termCount, .fifoEmpty, .idMatch, .atEot, .lastByte,
    .strb, .fifoRd, .headLoad, .done
  );

  floppy_wr_dp #(.MAXN(MAXN)) u_dp (
    .clk, .rstN, .strb, .cylIn, .headIn, .secIn, .sizeIn, .eotIn, .multiTrack,
    .idCyl, .idHead, .idSec, .idSize, .fifoData, .idMatch, .atEot, .lastByte,
    .wrValid, .wrByte, .st0, .st1, .resC, .resH, .resR, .resN
  );

  p_fifo_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |-> (wrValid && wrByte == fifoData && !fifoEmpty));

  p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emit == EMIT_DATA && !fifoRd) |-> (wrByte == 8'h00));

endmodule

// File: tb/floppy_wr_seq_tb.sv
module floppy_wr_seq_tb;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [7:0] cylIn = 0, headIn = 0, secIn = 0, sizeIn = 0, eotIn = 0;
  logic multiTrack = 0, headLoaded = 1;
  logic [15:0] settleCycles = 0;
  logic idValid = 0, idCrcOk = 1, indexPulse = 0, termCount = 0;
  logic [7:0] idCyl = 0, idHead = 0, idSec = 0, idSize = 0;
  logic fifoEmpty, fifoRd, headLoad, wrValid, done;
  logic [7:0] fifoData, wrByte, st0, st1, resC, resH, resR, resN;

  int total = 0, bad = 0, cycles = 0;
  int unsigned rdCount = 0, availLimit = 32'hFFFF_FFFF;
  int unsigned gIdx = 0;
  int pos = 0, lenCur = 128, cutPos = 100000, secDone = 0, bytesSeen = 0;
  bit cutB = 0, secOk = 1, tcMode = 0;
  logic [15:0] crcB = 16'hFFFF;

  always #2 clk = ~clk;

  assign fifoEmpty = (rdCount >= availLimit);
  assign fifoData  = 8'(rdCount) ^ 8'h5A;

  always @(posedge clk) if (fifoRd) rdCount <= rdCount + 1;

  floppy_wr_seq u_dut (.*);

  typedef struct packed {
    logic [7:0] c, h, r, n, eot;
    logic       mt;
    logic [7:0] ec, eh, er;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{8'd5, 8'd0, 8'd3, 8'd0, 8'd4, 1'b0, 8'd6,  8'd0, 8'd1},
    '{8'd5, 8'd0, 8'd2, 8'd0, 8'd2, 1'b1, 8'd5,  8'd1, 8'd1},
    '{8'd9, 8'd1, 8'd7, 8'd1, 8'd7, 1'b1, 8'd10, 8'd0, 8'd1},
    '{8'd2, 8'd1, 8'd1, 8'd0, 8'd1, 1'b0, 8'd3,  8'd1, 8'd1}
  };

  function automatic logic [15:0] refCrc(input logic [15:0] c0, input logic [7:0] b);
    logic [15:0] c;
    c = c0;
    for (int i = 7; i >= 0; i--) c = (c[15] ^ b[i]) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // byte-level monitor with its own model of field content and CRC
  always @(negedge clk) begin
    cycles++;
    if (rstN && wrValid) begin
      bytesSeen++;
      if (pos < lenCur) begin
        logic [7:0] e;
        if (!cutB && ((tcMode && pos >= cutPos) || gIdx >= availLimit)) cutB = 1;
        e = cutB ? 8'h00 : (8'(gIdx) ^ 8'h5A);
        if (!cutB) gIdx++;
        if (wrByte !== e) secOk = 0;
        crcB = refCrc(crcB, e);
        if (tcMode && pos == cutPos - 1) termCount = 1;
        pos++;
      end else if (pos == lenCur) begin
        if (wrByte !== crcB[15:8]) secOk = 0;
        pos++;
      end else begin
        if (wrByte !== crcB[7:0]) secOk = 0;
        chk(secOk, "R2/R3/R11 field bytes and CRC", wrByte, crcB[7:0]);
        secDone++;
        pos = 0; secOk = 1; crcB = 16'hFFFF;
      end
    end
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic startCmd(input logic [7:0] c, h, r, n, eot, input logic mt);
    @(negedge clk);
    cylIn = c; headIn = h; secIn = r; sizeIn = n; eotIn = eot; multiTrack = mt;
    lenCur = 128 << ((n > 2) ? 2 : n);
    cutB = 0; pos = 0; secOk = 1; crcB = 16'hFFFF;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic presentId(input logic [7:0] c, h, r, n, input logic ok);
    idCyl = c; idHead = h; idSec = r; idSize = n; idCrcOk = ok; idValid = 1;
    @(negedge clk);
    idValid = 0; idCrcOk = 1;
  endtask

  task automatic pulseIndex();
    indexPulse = 1;
    @(negedge clk);
    indexPulse = 0;
  endtask

  task automatic doSector(input logic [7:0] c, h, r, n);
    int s;
    s = secDone;
    repeat (3) @(negedge clk);
    presentId(c, h, r + 8'd40, n, 1'b1);
    @(negedge clk);
    presentId(c, h, r, n, 1'b1);
    while (secDone == s) @(negedge clk);
  endtask

  task automatic waitDone();
    while (done !== 1'b1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(done == 0 && headLoad == 0 && wrValid == 0, "R12 reset outputs idle", {done, headLoad, wrValid}, 0);
    chk(st0 == 0 && st1 == 0, "R12 reset status", {st0, st1}, 0);

    // table of full-track commands ending at end-of-track
    for (int v = 0; v < 4; v++) begin
      startCmd(VEC[v].c, VEC[v].h, VEC[v].r, VEC[v].n, VEC[v].eot, VEC[v].mt);
      for (logic [7:0] s = VEC[v].r; s <= VEC[v].eot; s++) doSector(VEC[v].c, VEC[v].h, s, VEC[v].n);
      waitDone();
      chk(resC == VEC[v].ec, "R10 result C", resC, VEC[v].ec);
      chk(resH == VEC[v].eh, "R10 result H", resH, VEC[v].eh);
      chk(resR == VEC[v].er && resN == VEC[v].n, "R10 result R,N", {resR, resN}, {VEC[v].er, VEC[v].n});
      chk(st0 == {5'b0, VEC[v].h[0], 2'b0} && st1 == 0, "R12 normal status", {st0, st1}, {5'b0, VEC[v].h[0], 2'b0});
      @(negedge clk);
      chk(done == 0, "R12 done single cycle", done, 0);
    end
    chk(secDone == 5, "R4 sectors written across table", secDone, 5);

    // R5 terminal count mid-field, below end-of-track
    tcMode = 1; cutPos = 20;
    startCmd(8'd3, 8'd0, 8'd3, 8'd0, 8'd9, 1'b0);
    doSector(8'd3, 8'd0, 8'd3, 8'd0);
    waitDone();
    chk(resR == 8'd4 && resC == 8'd3 && resH == 8'd0, "R9 result after terminal count", resR, 4);
    chk(st0 == 8'h00 && st1 == 8'h00, "R5 terminal count normal status", {st0, st1}, 0);
    termCount = 0; tcMode = 0; cutPos = 100000;

    // R6 underrun after 50 bytes
    availLimit = gIdx + 50;
    startCmd(8'd4, 8'd1, 8'd2, 8'd0, 8'd6, 1'b1);
    doSector(8'd4, 8'd1, 8'd2, 8'd0);
    waitDone();
    chk(st0 == 8'h44 && st1 == 8'h10, "R6 underrun status", {st0, st1}, 16'h4410);
    chk(resR == 8'd3 && resH == 8'd1, "R9 result after underrun", resR, 3);
    chk(rdCount == availLimit, "R6 no reads past empty", rdCount, availLimit);
    availLimit = 32'hFFFF_FFFF;

    // R7 bad ID CRC
    startCmd(8'd7, 8'd0, 8'd5, 8'd0, 8'd9, 1'b0);
    repeat (2) @(negedge clk);
    presentId(8'd7, 8'd0, 8'd1, 8'd0, 1'b0);
    waitDone();
    chk(st0 == 8'h40 && st1 == 8'h20, "R7 ID CRC error status", {st0, st1}, 16'h4020);
    chk(resC == 8'd7 && resR == 8'd5, "R7 unchanged address", {resC, resR}, 16'h0705);

    // R8 two index pulses without a match
    startCmd(8'd8, 8'd1, 8'd3, 8'd0, 8'd9, 1'b0);
    @(negedge clk);
    pulseIndex();
    presentId(8'd8, 8'd1, 8'd30, 8'd0, 1'b1);
    @(negedge clk);
    chk(done == 0, "R8 one index pulse keeps searching", done, 0);
    pulseIndex();
    waitDone();
    chk(st0 == 8'h44 && st1 == 8'h01, "R8 missing ID status", {st0, st1}, 16'h4401);

    // R1 settle wait with head unloaded; matching ID during wait is ignored
    headLoaded = 0; settleCycles = 16'd6;
    begin
      int b0;
      b0 = bytesSeen;
      startCmd(8'd1, 8'd0, 8'd4, 8'd0, 8'd4, 1'b0);
      chk(headLoad == 1, "R1 head load raised", headLoad, 1);
      presentId(8'd1, 8'd0, 8'd4, 8'd0, 1'b1);
      repeat (12) @(negedge clk);
      chk(bytesSeen == b0, "R1 ID during settle ignored", bytesSeen, b0);
    end
    doSector(8'd1, 8'd0, 8'd4, 8'd0);
    waitDone();
    chk(resC == 8'd2 && resR == 8'd1, "R10 end after settle", {resC, resR}, 16'h0201);
    @(negedge clk);
    chk(headLoad == 0, "R1 head load dropped after end", headLoad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule